// File: doc/BRIEF.md
# Processor-Port Memory Bank Decoder

This block models the small 8-bit I/O port that a processor exposes at the bottom two bytes of its 64K address space. Address `$0000` holds a direction register, where a 1 makes the matching pin an output. Address `$0001` holds the data port. The three lowest effective pin levels form a bank configuration, which the block registers. From that configuration, every CPU access is steered to exactly one target: RAM, BASIC ROM, KERNAL ROM, character ROM, I/O, or the port itself.

The decode covers three fixed 8K/4K windows at once: `$A000-$BFFF`, `$D000-$DFFF` and `$E000-$FFFF`. A two-bit code selects what appears in the upper-memory windows. A third bit chooses between character ROM and I/O in the `$D000` window, except when the code is zero, which leaves RAM everywhere. Writes that hit a ROM window go to the RAM underneath. Pins 3 to 5, which carry the cassette signals, are only stored, driven and read back; the block gives them no meaning of its own.

Top module: `mm_bank_decoder`

## Requirements
- R1: After reset, the direction register reads back as 0x2F and the data register holds 0x00. With all pins undriven, `$0001` reads back as 0xD0 and `cfg_bank` is 3'b000.
- R2: A write to `$0000` loads the direction register, and a later read of `$0000` returns it.
- R3: Each bit of a `$0001` read returns one of two values. Where the direction bit is 1, it returns the stored data bit. Where the direction bit is 0, it returns `pin_in` if the matching `pin_drv` bit is 1, and 1 otherwise.
- R4: When `cfg_bank[1:0]` is 00, every access outside the port bytes selects RAM, whatever `cfg_bank[2]` is.
- R5: When `cfg_bank[1:0]` is 01, both `$A000-$BFFF` and `$E000-$FFFF` select RAM.
- R6: When `cfg_bank[1:0]` is 10, `$A000-$BFFF` selects RAM and reads of `$E000-$FFFF` select KERNAL ROM.
- R7: When `cfg_bank[1:0]` is 11, reads of `$A000-$BFFF` select BASIC ROM and reads of `$E000-$FFFF` select KERNAL ROM.
- R8: When `cfg_bank[1:0]` is not 00, `$D000-$DFFF` selects character ROM for reads if `cfg_bank[2]` is 0, and I/O if `cfg_bank[2]` is 1.
- R9: A write that falls in a ROM or character-ROM window selects RAM instead. A write to the I/O window selects I/O.
- R10: Addresses `$0000` and `$0001` always select the port and never RAM. All other addresses outside the three windows select RAM.
- R11: During an access (read or write strobe high), exactly one select is high. With no strobe, all selects are low, and `port_rdata` is 0 unless a port byte is being read.
- R12: `cfg_bank` is a register holding effective pin levels 2..0. A port or direction write changes it at the same clock edge that stores the write. A change on the input pins shows up one edge later.
- R13: `pin_out` always shows the data register and `pin_oe` always shows the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe |
| cpu_re | input | 1 | Read strobe |
| pin_in | input | 8 | External pin levels |
| pin_drv | input | 8 | 1 where an external source drives the pin |
| port_rdata | output | 8 | Read data for `$0000`/`$0001` |
| cfg_bank | output | 3 | Registered bank configuration (bit 2 char/I/O, bits 1:0 code) |
| sel_ram | output | 1 | Access targets RAM |
| sel_basic | output | 1 | Access targets BASIC ROM |
| sel_kernal | output | 1 | Access targets KERNAL ROM |
| sel_char | output | 1 | Access targets character ROM |
| sel_io | output | 1 | Access targets I/O |
| sel_port | output | 1 | Access targets the port registers |
| pin_out | output | 8 | Data register driven to the pins |
| pin_oe | output | 8 | Direction register (output enables) |

## Verification
The assertions assume that the read and write strobes are never high together, and that the address and strobes are stable between clock edges. The stimulus changes every input only on the falling clock edge and raises at most one strobe per cycle. For the pin-driven configuration case, the bench changes pin levels only while no access is in progress, and waits one extra edge before checking `cfg_bank` against its own pin model.

// File: rtl/mm_pkg.sv
package mm_pkg;

    // One-hot access target
    typedef struct packed {
        logic port;
        logic io;
        logic chr;
        logic kernal;
        logic basic;
        logic ram;
    } region_sel_t;

    // Registered bank configuration
    typedef struct packed {
        logic       d_io;   // 1: I/O in the $D000 window, 0: character ROM
        logic [1:0] code;   // upper-memory code
    } bank_cfg_t;

    localparam int unsigned CFG_W = 3;

    // Window prefixes, taken from the top of the address
    localparam logic [2:0] PFX_A_WIN = 3'b101;   // $A000-$BFFF
    localparam logic [3:0] PFX_D_WIN = 4'hD;     // $D000-$DFFF
    localparam logic [2:0] PFX_E_WIN = 3'b111;   // $E000-$FFFF

endpackage

// File: rtl/mm_port_regs.sv
module mm_port_regs #(
    parameter int unsigned DATA_W   = 8,
    parameter logic [7:0]  DDR_RST  = 8'h2F,
    parameter logic [7:0]  PORT_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ddr,
    input  logic              wr_port,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pin_in,
    input  logic [DATA_W-1:0] pin_drv,
    output logic [DATA_W-1:0] ddr_q,
    output logic [DATA_W-1:0] port_q,
    output logic [DATA_W-1:0] eff_now,
    output logic [DATA_W-1:0] eff_next
);

    typedef struct packed {
        logic [DATA_W-1:0] ddr;
        logic [DATA_W-1:0] port;
    } regs_t;

    regs_t r_d, r_q;
    logic [DATA_W-1:0] level;

    always_comb begin
        r_d = r_q;
        if (wr_ddr) begin
            r_d.ddr = wdata;
        end
        if (wr_port) begin
            r_d.port = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ddr  <= DDR_RST[DATA_W-1:0];
            r_q.port <= PORT_RST[DATA_W-1:0];
        end else begin
            r_q <= r_d;
        end
    end

    // Per-pin resolution: an undriven pin floats high
    for (genvar b = 0; b < DATA_W; b++) begin : g_pin
        assign level[b]    = pin_drv[b] ? pin_in[b] : 1'b1;
        assign eff_now[b]  = r_q.ddr[b] ? r_q.port[b] : level[b];
        assign eff_next[b] = r_d.ddr[b] ? r_d.port[b] : level[b];
    end

    assign ddr_q  = r_q.ddr;
    assign port_q = r_q.port;

endmodule

// File: rtl/mm_region_decode.sv
module mm_region_decode
    import mm_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  bank_cfg_t         cfg,
    output region_sel_t       sel
);

    logic port_hit, in_a, in_d, in_e, roms_on;
    logic basic_hit, kern_hit, char_hit, io_hit;

    always_comb begin
        port_hit  = (addr[ADDR_W-1:1] == '0);
        in_a      = (addr[ADDR_W-1 -: 3] == PFX_A_WIN);
        in_d      = (addr[ADDR_W-1 -: 4] == PFX_D_WIN);
        in_e      = (addr[ADDR_W-1 -: 3] == PFX_E_WIN);
        roms_on   = (cfg.code != 2'b00);
        basic_hit = in_a && (cfg.code == 2'b11);
        kern_hit  = in_e && cfg.code[1];
        char_hit  = in_d && roms_on && !cfg.d_io;
        io_hit    = in_d && roms_on && cfg.d_io;

        sel = '0;
        if (we || re) begin
            if (port_hit) begin
                sel.port = 1'b1;
            end else if (io_hit) begin
                sel.io = 1'b1;
            end else if (we) begin
                sel.ram = 1'b1;     // writes under ROM land in RAM
            end else if (basic_hit) begin
                sel.basic = 1'b1;
            end else if (kern_hit) begin
                sel.kernal = 1'b1;
            end else if (char_hit) begin
                sel.chr = 1'b1;
            end else begin
                sel.ram = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mm_bank_decoder.sv
module mm_bank_decoder
    import mm_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter logic [7:0]  DDR_RST  = 8'h2F,
    parameter logic [7:0]  PORT_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    input  logic              cpu_re,
    input  logic [DATA_W-1:0] pin_in,
    input  logic [DATA_W-1:0] pin_drv,
    output logic [DATA_W-1:0] port_rdata,
    output logic [2:0]        cfg_bank,
    output logic              sel_ram,
    output logic              sel_basic,
    output logic              sel_kernal,
    output logic              sel_char,
    output logic              sel_io,
    output logic              sel_port,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe
);

    logic              hit_port_pair;
    logic              wr_ddr, wr_port;
    logic [DATA_W-1:0] ddr_q, port_q, eff_now, eff_next;
    bank_cfg_t         cfg_d, cfg_q;
    region_sel_t       sel;

    assign hit_port_pair = (cpu_addr[ADDR_W-1:1] == '0);
    assign wr_ddr        = cpu_we && hit_port_pair && !cpu_addr[0];
    assign wr_port       = cpu_we && hit_port_pair &&  cpu_addr[0];

    mm_port_regs #(
        .DATA_W  (DATA_W),
        .DDR_RST (DDR_RST),
        .PORT_RST(PORT_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ddr  (wr_ddr),
        .wr_port (wr_port),
        .wdata   (cpu_wdata),
        .pin_in  (pin_in),
        .pin_drv (pin_drv),
        .ddr_q   (ddr_q),
        .port_q  (port_q),
        .eff_now (eff_now),
        .eff_next(eff_next)
    );

    // Bank configuration register: follows the next effective pin levels
    always_comb begin
        cfg_d = bank_cfg_t'(eff_next[CFG_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= bank_cfg_t'(DDR_RST[CFG_W-1:0] & PORT_RST[CFG_W-1:0]);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    mm_region_decode #(
        .ADDR_W(ADDR_W)
    ) u_dec (
        .addr(cpu_addr),
        .we  (cpu_we),
        .re  (cpu_re),
        .cfg (cfg_q),
        .sel (sel)
    );

    always_comb begin
        port_rdata = '0;
        if (cpu_re && hit_port_pair) begin
            port_rdata = cpu_addr[0] ? eff_now : ddr_q;
        end
    end

    assign cfg_bank   = cfg_q;
    assign sel_ram    = sel.ram;
    assign sel_basic  = sel.basic;
    assign sel_kernal = sel.kernal;
    assign sel_char   = sel.chr;
    assign sel_io     = sel.io;
    assign sel_port   = sel.port;
    assign pin_out    = port_q;
    assign pin_oe     = ddr_q;

endmodule

// File: rtl/mm_bank_decoder_chk.sv
module mm_bank_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_we,
    input logic        cpu_re,
    input logic [2:0]  cfg_bank,
    input logic        sel_ram,
    input logic        sel_basic,
    input logic        sel_kernal,
    input logic        sel_char,
    input logic        sel_io,
    input logic        sel_port,
    input logic [7:0]  pin_out,
    input logic [7:0]  pin_oe
);

    logic [5:0] sels;
    logic       in_a, in_d;
    assign sels = {sel_port, sel_io, sel_char, sel_kernal, sel_basic, sel_ram};
    assign in_a = (cpu_addr[15:13] == 3'b101);
    assign in_d = (cpu_addr[15:12] == 4'hD);

    // Input assumption: never both strobes
    a_in_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && cpu_re));

    // R11
    a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we || cpu_re) |-> ($countones(sels) == 1));
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we || cpu_re) |-> (sels == 6'b0));

    // R4
    a_r4_all_ram: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_we || cpu_re) && cfg_bank[1:0] == 2'b00 && cpu_addr[15:1] != 15'd0)
        |-> sel_ram);

    // R7
    a_r7_basic_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_re && cfg_bank[1:0] == 2'b11 && in_a) |-> sel_basic);

    // R8
    a_r8_char_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_re && cfg_bank[1:0] != 2'b00 && !cfg_bank[2] && in_d) |-> sel_char);

    // R9
    a_r9_write_no_rom: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |-> !(sel_basic || sel_kernal || sel_char));

    // R10
    a_r10_port_not_ram: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_we || cpu_re) && cpu_addr[15:1] == 15'd0) |-> (sel_port && !sel_ram));

    // R2 / R13
    a_r2_ddr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 16'h0000) |=> (pin_oe == $past(cpu_wdata)));
    a_r13_port_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 16'h0001) |=> (pin_out == $past(cpu_wdata)));

    // R12: an output-direction bit written to the port lands in the config
    a_r12_cfg_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 16'h0001 && pin_oe[2:0] == 3'b111)
        |=> (cfg_bank == $past(cpu_wdata[2:0])));

endmodule

bind mm_bank_decoder mm_bank_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .cpu_re    (cpu_re),
    .cfg_bank  (cfg_bank),
    .sel_ram   (sel_ram),
    .sel_basic (sel_basic),
    .sel_kernal(sel_kernal),
    .sel_char  (sel_char),
    .sel_io    (sel_io),
    .sel_port  (sel_port),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/tb_mm_bank_decoder.sv
module tb_mm_bank_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic        cpu_re = 1'b0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_drv = '0;
    logic [7:0]  port_rdata;
    logic [2:0]  cfg_bank;
    logic        sel_ram, sel_basic, sel_kernal, sel_char, sel_io, sel_port;
    logic [7:0]  pin_out, pin_oe;

    always #2 clk = ~clk;   // 250 MHz

    mm_bank_decoder dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_re(cpu_re), .pin_in(pin_in), .pin_drv(pin_drv),
        .port_rdata(port_rdata), .cfg_bank(cfg_bank),
        .sel_ram(sel_ram), .sel_basic(sel_basic), .sel_kernal(sel_kernal),
        .sel_char(sel_char), .sel_io(sel_io), .sel_port(sel_port),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Select encoding used by the bench: {port, io, char, kernal, basic, ram}
    localparam logic [7:0] S_RAM = 8'h01, S_BASIC = 8'h02, S_KERN = 8'h04,
                           S_CHAR = 8'h08, S_IO = 8'h10, S_PORT = 8'h20,
                           S_NONE = 8'h00;
    localparam int K_SEL = 0, K_RDATA = 1, K_CFG = 2, K_POUT = 3, K_POE = 4;

    typedef struct {
        string      req;
        int         kind;
        logic [7:0] exp;
    } item_t;

    item_t queue_q[$];
    event  ev_sample;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // Monitor: compare everything queued for this cycle
    initial begin
        forever begin
            @(ev_sample);
            #1;
            while (queue_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = queue_q.pop_front();
                case (it.kind)
                    K_SEL:   act = {2'b00, sel_port, sel_io, sel_char, sel_kernal, sel_basic, sel_ram};
                    K_RDATA: act = port_rdata;
                    K_CFG:   act = {5'b0, cfg_bank};
                    K_POUT:  act = pin_out;
                    default: act = pin_oe;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(input int kind, input logic [7:0] exp, input string req);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        queue_q.push_back(it);
    endtask

    // Drive one cycle of stimulus at the falling edge, then trigger sampling
    task automatic drive(input logic [15:0] a, input logic [7:0] d, input logic we, input logic re);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = we; cpu_re = re;
    endtask

    task automatic sample();
        -> ev_sample;
        #1.5;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp_sel, input string req);
        drive(a, 8'h00, 1'b0, 1'b1);
        expect_v(K_SEL, exp_sel, req);
        sample();
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [7:0] exp_sel, input string req);
        drive(a, d, 1'b1, 1'b0);
        expect_v(K_SEL, exp_sel, req);
        sample();
    endtask

    task automatic idle();
        drive(16'h0200, 8'h00, 1'b0, 1'b0);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        drive(16'h0000, 8'h00, 1'b0, 1'b1);
        expect_v(K_RDATA, 8'h2F, "R1 ddr reset");
        expect_v(K_CFG, 8'h00, "R1 cfg reset");
        expect_v(K_POUT, 8'h00, "R1 R13 port reset");
        sample();
        drive(16'h0001, 8'h00, 1'b0, 1'b1);
        expect_v(K_RDATA, 8'hD0, "R1 R3 port readback");
        expect_v(K_SEL, S_PORT, "R10 port read");
        sample();
        rd(16'hD000, S_RAM, "R4 D window all RAM");
        rd(16'hA000, S_RAM, "R4 A window all RAM");
        idle();
        expect_v(K_SEL, S_NONE, "R11 idle");
        expect_v(K_RDATA, 8'h00, "R11 idle rdata");
        sample();

        // Code 11, I/O
        wr(16'h0001, 8'h07, S_PORT, "R10 port write");
        idle();
        expect_v(K_CFG, 8'h07, "R12 cfg after write");
        expect_v(K_POUT, 8'h07, "R13 pin_out");
        sample();
        rd(16'hA000, S_BASIC, "R7 A basic");
        rd(16'hBFFF, S_BASIC, "R7 A top basic");
        rd(16'hE000, S_KERN, "R7 E kernal");
        rd(16'hD020, S_IO, "R8 D io");
        rd(16'hC000, S_RAM, "R10 C000 ram");
        rd(16'h9FFF, S_RAM, "R10 9FFF ram");
        rd(16'h0002, S_RAM, "R10 0002 ram");
        drive(16'h0001, 8'h00, 1'b0, 1'b1);
        expect_v(K_RDATA, 8'hD7, "R3 port readback outputs high");
        sample();
        wr(16'hA000, 8'h55, S_RAM, "R9 write under basic");
        wr(16'hE123, 8'h55, S_RAM, "R9 write under kernal");
        wr(16'hD020, 8'h55, S_IO, "R9 write to io");

        // Code 11, char
        wr(16'h0001, 8'h03, S_PORT, "R10 port write");
        rd(16'hD000, S_CHAR, "R8 D char");
        wr(16'hD000, 8'h11, S_RAM, "R9 write under char");

        // Code 10
        wr(16'h0001, 8'h06, S_PORT, "R10 port write");
        rd(16'hA000, S_RAM, "R6 A ram");
        rd(16'hFFFF, S_KERN, "R6 E kernal");
        rd(16'hDFFF, S_IO, "R8 D io code10");

        // Code 01
        wr(16'h0001, 8'h01, S_PORT, "R10 port write");
        rd(16'hA000, S_RAM, "R5 A ram");
        rd(16'hE000, S_RAM, "R5 E ram");
        rd(16'hD000, S_CHAR, "R8 D char code01");

        // Code 00 with bit2 set
        wr(16'h0001, 8'h04, S_PORT, "R10 port write");
        idle();
        expect_v(K_CFG, 8'h04, "R12 cfg code00");
        sample();
        rd(16'hD000, S_RAM, "R4 D ram despite bit2");
        rd(16'hE000, S_RAM, "R4 E ram");

        // Direction change: bits 1:0 become inputs, undriven so high
        wr(16'h0000, 8'h2C, S_PORT, "R10 ddr write");
        idle();
        expect_v(K_CFG, 8'h07, "R12 cfg from pulled-up inputs");
        expect_v(K_POE, 8'h2C, "R13 pin_oe");
        sample();
        drive(16'h0000, 8'h00, 1'b0, 1'b1);
        expect_v(K_RDATA, 8'h2C, "R2 ddr readback");
        sample();
        rd(16'hA000, S_BASIC, "R7 basic via pulled-up inputs");

        // Drive pin1 low, pin0 high from outside
        @(negedge clk);
        cpu_we = 1'b0; cpu_re = 1'b0;
        pin_drv = 8'h03; pin_in = 8'h01;
        @(negedge clk);
        expect_v(K_CFG, 8'h05, "R12 cfg follows pins one edge later");
        sample();
        drive(16'h0001, 8'h00, 1'b0, 1'b1);
        expect_v(K_RDATA, 8'hD5, "R3 mixed readback");
        sample();
        rd(16'hE000, S_RAM, "R5 E ram from pins");

        idle();
        repeat (2) @(posedge clk);
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule